// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block steers a circular sample memory for a logic-analyser style capture. Once a run is started it produces a write enable and a ring address for every sample strobe, so the sample stream wraps continuously through the memory. A trigger is accepted only after the programmed pretrigger depth has been recorded. After the trigger it writes a programmed number of further samples and then halts with a done flag set. A stop request ends the capture early. When pretrigger is disabled, nothing is recorded until the trigger arrives, and the whole setting is spent on post-trigger samples.

The ring is split in steps of one segment, where a segment is 2^(ADDR_W-SET_W) entries. The memory array and the trigger detector live outside the block. When capture has finished, the same address counter is used to read the memory back. A single-step request moves it by one entry. In auto-increment mode it also moves after the last byte lane of an entry has been read. A saturating sample counter raises a top flag once a full ring of writes plus read steps has gone by. Software uses that flag to find where the oldest data begins. A clear request returns the sequencer to idle and leaves the latched settings untouched.

Top module: `capseq_top`

## Requirements
- R1: A run request is accepted only in idle. It latches `pre_sel_i` and `pre_dis_i`, and the lengths of that capture follow the latched values even if the inputs change later.
- R2: `mem_we_o` equals `sample_i` while recording and is 0 otherwise. Each write advances `mem_addr_o` by one, modulo 2^ADDR_W.
- R3: With pretrigger enabled and setting P below its maximum, the pretrigger depth is (P+1) segments and the post-trigger length is the ring size minus that depth.
- R4: With pretrigger enabled and P at its all-ones value, the pretrigger depth is ring size minus one and exactly one post-trigger sample is written.
- R5: With pretrigger disabled, no write occurs before the trigger, and (P+1) segments are written after it.
- R6: A trigger pulse is ignored while fewer writes than the pretrigger depth have happened since run. A trigger in the same cycle as a write counts that write as pretrigger.
- R7: Post-trigger samples are the writes in the cycles after the trigger is accepted. `done_o` rises the cycle after the last of them, and from then on no write occurs. `mem_addr_o` then points at the next ring position, which is the oldest sample when the ring has been filled.
- R8: A stop request while capturing ends the capture and sets `done_o` the next cycle. `done_o` and `mem_addr_o` hold until clear, and run or trigger requests have no effect while done.
- R9: `sct_o` rises once the total of writes and read steps since clear reaches 2^ADDR_W, and it stays high until clear.
- R10: While done, a `step_i` pulse advances `mem_addr_o` by one. Outside done, `step_i` has no effect.
- R11: `byte_lane_o` counts `byte_rd_i` pulses modulo LANES. While done with `auto_inc_i` high, a read at lane LANES-1 advances the address. A step and such a read in the same cycle advance the address by one only.
- R12: `clear_i` has priority over every other request. The next cycle shows idle with address 0, `done_o`, `sct_o` and lane at 0. The reset state is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Start capture request (pulse) |
| stop_i | input | 1 | Abort capture request (pulse) |
| clear_i | input | 1 | Return to idle request (pulse) |
| sample_i | input | 1 | Sample strobe from the timebase |
| trig_i | input | 1 | Trigger pulse from the trigger detector |
| pre_sel_i | input | SET_W | Segment setting P |
| pre_dis_i | input | 1 | 1 disables pretrigger recording |
| step_i | input | 1 | Single read-step request |
| auto_inc_i | input | 1 | Auto-increment on last byte read |
| byte_rd_i | input | 1 | One byte of the current entry was read |
| mem_addr_o | output | ADDR_W | Ring address for write and read |
| mem_we_o | output | 1 | Memory write enable |
| done_o | output | 1 | Capture finished or aborted |
| sct_o | output | 1 | Sample counter reached ring size |
| byte_lane_o | output | $clog2(LANES) | Byte lane of the next read |

## Verification
The bench builds the block with ADDR_W=6, SET_W=4 and LANES=4, which gives a 64-entry ring made of sixteen 4-entry segments. At that size, every pretrigger setting can be run to completion within a few hundred cycles, including the all-ones setting in both modes. Ring wrap, saturation of the sample counter, and read stepping across the wrap are all reached many times over. Randomised strobe density, trigger timing, stop and clear timing, and readback traffic are mixed with directed cases for each requirement.

// File: rtl/capseq_pkg.sv
// Shared types for the capture sequencer.
package capseq_pkg;
    // Sequencer phases: idle, recording before trigger, waiting for trigger
    // without recording, recording after trigger, finished.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_HOLD = 3'd2,
        ST_POST = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;
endpackage

// File: rtl/capseq_len_calc.sv
// Computes pretrigger depth and post-trigger length from the segment setting.
// Assumes ADDR_W > SET_W; a segment is 2**(ADDR_W-SET_W) entries.
module capseq_len_calc #(
    parameter int ADDR_W = 17,
    parameter int SET_W  = 4
) (
    input  logic [SET_W-1:0]  sel_i,
    input  logic              dis_i,
    output logic [ADDR_W:0]   pre_len_o,
    output logic [ADDR_W:0]   post_len_o
);
    localparam int CW    = ADDR_W + 1;
    localparam int SEG_W = ADDR_W - SET_W;
    localparam logic [CW-1:0] RING = CW'(1) << ADDR_W;

    logic [CW-1:0] span;

    // Length table: segments in use, with the all-ones setting special-cased.
    always_comb begin
        span = ({{(CW-SET_W){1'b0}}, sel_i} + CW'(1)) << SEG_W;
        if (dis_i) begin
            pre_len_o  = '0;
            post_len_o = span;
        end else if (&sel_i) begin
            pre_len_o  = RING - CW'(1);
            post_len_o = CW'(1);
        end else begin
            pre_len_o  = span;
            post_len_o = RING - span;
        end
    end
endmodule

// File: rtl/capseq_fsm.sv
// Capture phase controller: run/stop/clear handling, trigger gating,
// post-trigger counting and write enable. Assumes cnt_i is the number of
// writes since clear, supplied by the address counter.
module capseq_fsm
    import capseq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              stop_i,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              trig_i,
    input  logic [SET_W-1:0]  pre_sel_i,
    input  logic              pre_dis_i,
    input  logic [ADDR_W:0]   cnt_i,
    input  logic [ADDR_W:0]   pre_len_i,
    input  logic [ADDR_W:0]   post_len_i,
    output logic [SET_W-1:0]  cfg_sel_o,
    output logic              cfg_dis_o,
    output logic              we_o,
    output logic              done_o
);
    localparam int CW = ADDR_W + 1;

    seq_state_t     state_q, state_d;
    logic [CW-1:0]  post_q;
    logic           recording;
    logic           capturing;
    logic           trig_ok;
    logic           last_post;

    assign recording = (state_q == ST_FILL) || (state_q == ST_POST);
    assign capturing = recording || (state_q == ST_HOLD);
    assign we_o      = sample_i && recording;
    assign done_o    = (state_q == ST_DONE);
    assign trig_ok   = trig_i && (((state_q == ST_FILL) && (cnt_i >= pre_len_i))
                                  || (state_q == ST_HOLD));
    assign last_post = sample_i && (post_q == post_len_i - CW'(1));

    // Next-phase selection with clear > stop > normal progress.
    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = ST_IDLE;
        end else if (stop_i && capturing) begin
            state_d = ST_DONE;
        end else begin
            case (state_q)
                ST_IDLE: if (run_i) state_d = pre_dis_i ? ST_HOLD : ST_FILL;
                ST_FILL: if (trig_ok) state_d = ST_POST;
                ST_HOLD: if (trig_ok) state_d = ST_POST;
                ST_POST: if (last_post) state_d = ST_DONE;
                default: state_d = state_q;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Post-trigger write counter, zeroed when the trigger is taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                     post_q <= '0;
        else if (trig_ok && !stop_i)               post_q <= '0;
        else if (state_q == ST_POST && sample_i)   post_q <= post_q + CW'(1);
    end

    // Settings latch, loaded on an accepted run; clear leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_sel_o <= '0;
            cfg_dis_o <= 1'b0;
        end else if (!clear_i && run_i && state_q == ST_IDLE) begin
            cfg_sel_o <= pre_sel_i;
            cfg_dis_o <= pre_dis_i;
        end
    end

    // R7: post counter stays below the programmed length while in POST.
    assert_post_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |-> (post_q < post_len_i));

    // R6: early trigger does not leave the fill phase.
    assert_trig_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && trig_i && !stop_i && !clear_i && cnt_i < pre_len_i)
        |=> (state_q == ST_FILL));

    // R8: done holds until clear.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !clear_i) |=> (state_q == ST_DONE));
endmodule

// File: rtl/capseq_addr_ctr.sv
// Ring address and saturating sample counter. Advances on a write or on a
// read step; the two never coincide because writes stop once done.
module capseq_addr_ctr #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic              rd_adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W:0]   cnt_o,
    output logic              sct_o
);
    localparam int CW = ADDR_W + 1;
    localparam logic [CW-1:0] RING = CW'(1) << ADDR_W;

    logic advance;

    assign advance = we_i || rd_adv_i;
    assign sct_o   = (cnt_o == RING);

    // Address wraps naturally at 2**ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) addr_o <= '0;
        else if (advance)      addr_o <= addr_o + ADDR_W'(1);
    end

    // Counter stops at the ring size.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)         cnt_o <= '0;
        else if (advance && !sct_o)    cnt_o <= cnt_o + CW'(1);
    end

    // R2: each write moves the address by one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clear_i) |=> (addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1))));

    // R9: top flag is sticky until clear.
    assert_sct_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sct_o && !clear_i) |=> sct_o);

    // R12: clear empties address and counter.
    assert_clear_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (addr_o == '0 && cnt_o == '0));
endmodule

// File: rtl/capseq_byte_lane.sv
// Byte lane selector for reading a wide entry through a byte-wide port.
// Assumes LANES >= 2.
module capseq_byte_lane #(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              byte_rd_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              last_rd_o
);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    assign last_rd_o = byte_rd_i && (lane_o == LAST);

    // Lane counter, wrapping after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) lane_o <= '0;
        else if (last_rd_o)    lane_o <= '0;
        else if (byte_rd_i)    lane_o <= lane_o + LANE_W'(1);
    end

    // R11: reading the last lane wraps to lane 0.
    assert_lane_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_rd_i && lane_o == LAST && !clear_i) |=> (lane_o == '0));
endmodule

// File: rtl/capseq_top.sv
// Capture sequencer top: ties the phase controller, length table, ring
// address counter and byte lane selector together. The memory array and
// the trigger detector are outside this block.
module capseq_top #(
    parameter int ADDR_W = 17,
    parameter int SET_W  = 4,
    parameter int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              stop_i,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              trig_i,
    input  logic [SET_W-1:0]  pre_sel_i,
    input  logic              pre_dis_i,
    input  logic              step_i,
    input  logic              auto_inc_i,
    input  logic              byte_rd_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              done_o,
    output logic              sct_o,
    output logic [LANE_W-1:0] byte_lane_o
);
    logic [SET_W-1:0] cfg_sel;
    logic             cfg_dis;
    logic [ADDR_W:0]  pre_len;
    logic [ADDR_W:0]  post_len;
    logic [ADDR_W:0]  cnt;
    logic             last_rd;
    logic             rd_adv;

    // Read stepping is only honoured once capture has finished.
    assign rd_adv = done_o && (step_i || (auto_inc_i && last_rd));

    capseq_len_calc #(.ADDR_W(ADDR_W), .SET_W(SET_W)) len_i (
        .sel_i      (cfg_sel),
        .dis_i      (cfg_dis),
        .pre_len_o  (pre_len),
        .post_len_o (post_len)
    );

    capseq_fsm #(.ADDR_W(ADDR_W), .SET_W(SET_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .stop_i     (stop_i),
        .clear_i    (clear_i),
        .sample_i   (sample_i),
        .trig_i     (trig_i),
        .pre_sel_i  (pre_sel_i),
        .pre_dis_i  (pre_dis_i),
        .cnt_i      (cnt),
        .pre_len_i  (pre_len),
        .post_len_i (post_len),
        .cfg_sel_o  (cfg_sel),
        .cfg_dis_o  (cfg_dis),
        .we_o       (mem_we_o),
        .done_o     (done_o)
    );

    capseq_addr_ctr #(.ADDR_W(ADDR_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .we_i     (mem_we_o),
        .rd_adv_i (rd_adv),
        .addr_o   (mem_addr_o),
        .cnt_o    (cnt),
        .sct_o    (sct_o)
    );

    capseq_byte_lane #(.LANES(LANES), .LANE_W(LANE_W)) lane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .byte_rd_i (byte_rd_i),
        .lane_o    (byte_lane_o),
        .last_rd_o (last_rd)
    );

    // R10: a step outside done leaves the address alone (no write that cycle).
    assert_step_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !mem_we_o && !clear_i) |=> $stable(mem_addr_o));
endmodule

// File: tb/capseq_top_tb_top.sv
// Self-checking bench: cycle-level reference built from the requirements.
module capseq_top_tb_top;
    localparam int AW = 6;
    localparam int SW = 4;
    localparam int LN = 4;
    localparam int N  = 64;
    localparam int SEGL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 0, stop_i = 0, clear_i = 0, sample_i = 0, trig_i = 0;
    logic [SW-1:0] pre_sel_i = '0;
    logic pre_dis_i = 0, step_i = 0, auto_inc_i = 0, byte_rd_i = 0;
    logic [AW-1:0] mem_addr_o;
    logic mem_we_o, done_o, sct_o;
    logic [1:0] byte_lane_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R12";

    // reference state: 0 idle, 1 fill, 2 hold, 3 post, 4 done
    int m_st = 0, m_addr = 0, m_cnt = 0, m_lane = 0, m_post = 0, m_sel = 0;
    bit m_dis = 0;

    always #4 clk = ~clk;

    capseq_top #(.ADDR_W(AW), .SET_W(SW), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .stop_i(stop_i),
        .clear_i(clear_i), .sample_i(sample_i), .trig_i(trig_i),
        .pre_sel_i(pre_sel_i), .pre_dis_i(pre_dis_i), .step_i(step_i),
        .auto_inc_i(auto_inc_i), .byte_rd_i(byte_rd_i),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .done_o(done_o),
        .sct_o(sct_o), .byte_lane_o(byte_lane_o)
    );

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // R3/R4/R5 length rules
    function automatic int f_pre(int sel, bit dis);
        if (dis) return 0;
        if (sel == 15) return N - 1;
        return (sel + 1) * SEGL;
    endfunction

    function automatic int f_post(int sel, bit dis);
        if (dis) return (sel + 1) * SEGL;
        if (sel == 15) return 1;
        return N - (sel + 1) * SEGL;
    endfunction

    task automatic model_step(bit r, bit s, bit c, bit smp, bit trg, bit stp, bit brd);
        int ost = m_st;
        int olane = m_lane;
        int ocnt = m_cnt;
        bit wexp = smp && (ost == 1 || ost == 3);
        bit adv;
        if (c) begin
            m_st = 0; m_addr = 0; m_cnt = 0; m_lane = 0; m_post = 0;
            return;
        end
        if (brd) m_lane = (m_lane + 1) % LN;
        adv = wexp || (ost == 4 && (stp || (auto_inc_i && brd && olane == LN - 1)));
        if (adv) begin
            m_addr = (m_addr + 1) % N;
            if (m_cnt < N) m_cnt++;
        end
        if (s && ost >= 1 && ost <= 3) m_st = 4;
        else case (ost)
            0: if (r) begin m_sel = pre_sel_i; m_dis = pre_dis_i; m_st = pre_dis_i ? 2 : 1; end
            1: if (trg && ocnt >= f_pre(m_sel, m_dis)) begin m_st = 3; m_post = 0; end
            2: if (trg) begin m_st = 3; m_post = 0; end
            3: if (smp) begin
                   if (m_post + 1 == f_post(m_sel, m_dis)) m_st = 4;
                   else m_post++;
               end
            default: ;
        endcase
    endtask

    // One cycle: drive at negedge, check write enable, then registered outputs.
    task automatic cyc(bit r, bit s, bit c, bit smp, bit trg, bit stp, bit brd);
        run_i = r; stop_i = s; clear_i = c; sample_i = smp; trig_i = trg;
        step_i = stp; byte_rd_i = brd;
        #1;
        chk("R2 we", mem_we_o, (smp && (m_st == 1 || m_st == 3)) ? 1 : 0);
        model_step(r, s, c, smp, trg, stp, brd);
        @(posedge clk);
        @(negedge clk);
        chk("R2 addr", mem_addr_o, m_addr);
        chk("R7 done", done_o, (m_st == 4) ? 1 : 0);
        chk("R9 sct", sct_o, (m_cnt == N) ? 1 : 0);
        chk("R11 lane", byte_lane_o, m_lane);
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Run one capture: density in percent, trigger and stop at given cycles.
    task automatic capture(int sel, bit dis, int trig_at, int dens, int stop_at);
        pre_sel_i = SW'(sel); pre_dis_i = dis;
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 700 && m_st != 4; i++) begin
            cyc(0, i == stop_at, 0, ($urandom % 100) < dens, i == trig_at || (trig_at < 0 && i % 37 == 36), 0, 0);
        end
    endtask

    task automatic readback(int n);
        for (int i = 0; i < n; i++) begin
            auto_inc_i = $urandom % 2;
            cyc(0, 0, 0, 0, 0, ($urandom % 5) == 0, ($urandom % 2) == 0);
        end
    endtask

    task automatic do_clear();
        cyc(0, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R12";
        chk("R12 reset addr", mem_addr_o, 0);
        chk("R12 reset done", done_o, 0);
        chk("R12 reset sct", sct_o, 0);
        chk("R12 reset lane", byte_lane_o, 0);
        idle_cyc();
        cyc(0, 0, 0, 1, 1, 1, 0);   // idle: sample, trigger, step do nothing

        // R6: early trigger ignored, then R3 length with P=2 (pre 12, post 52)
        cur_req = "R6";
        pre_sel_i = 4'd2; pre_dis_i = 0;
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 11; i++) cyc(0, 0, 0, 1, i == 5, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0);   // 12th write coincides with trigger: ignored
        cur_req = "R3";
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, i == 7, 0, 0);
        for (int i = 0; i < 60 && m_st != 4; i++) cyc(0, 0, 0, 1, 0, 0, 0);
        cur_req = "R7";
        chk("R7 done after post", done_o, 1);
        chk("R7 oldest addr", mem_addr_o, (20 + 52) % N);
        cyc(0, 0, 0, 1, 1, 0, 0);   // no write when done
        cur_req = "R8";
        cyc(1, 0, 0, 1, 1, 0, 0);   // run ignored in done
        chk("R8 done held", done_o, 1);

        // R10 / R11 readback
        cur_req = "R10";
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        cur_req = "R11";
        auto_inc_i = 1;
        for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);   // lane 1 + step
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);   // lane 3 read + step: single advance
        auto_inc_i = 0;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1);
        do_clear();

        // R4: all-ones setting, pretrigger enabled
        cur_req = "R4";
        capture(15, 0, 70, 100, -1);
        chk("R4 finished", done_o, 1);
        do_clear();

        // R5: pretrigger disabled, P=3 -> 16 samples after trigger
        cur_req = "R5";
        capture(3, 1, 10, 100, -1);
        chk("R5 addr", mem_addr_o, 16);
        chk("R5 sct", sct_o, 0);
        cur_req = "R9";
        for (int i = 0; i < 48; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R9 sct after wrap", sct_o, 1);
        do_clear();

        // R8: stop mid capture
        cur_req = "R8";
        capture(6, 0, 200, 100, 9);
        chk("R8 stopped", done_o, 1);
        cyc(0, 0, 0, 1, 1, 0, 0);
        do_clear();

        // R1: settings latched at run
        cur_req = "R1";
        pre_sel_i = 4'd1; pre_dis_i = 0;
        cyc(1, 0, 0, 0, 0, 0, 0);
        pre_sel_i = 4'd14; pre_dis_i = 1;
        for (int i = 0; i < 80 && m_st != 4; i++) cyc(0, 0, 0, 1, i == 10, 0, 0);
        chk("R1 latched lengths", mem_addr_o, (11 + 56) % N);

        // R12: clear wins over run and stop
        cur_req = "R12";
        cyc(1, 1, 1, 1, 1, 1, 1);
        cyc(0, 0, 0, 1, 0, 0, 0);

        // Random mix
        for (int k = 0; k < 30; k++) begin
            cur_req = "R2";
            capture($urandom % 16, $urandom % 2, $urandom % 150,
                    30 + ($urandom % 71), (($urandom % 4) == 0) ? ($urandom % 120) : -1);
            cur_req = "R10";
            readback(60 + ($urandom % 80));
            cur_req = "R12";
            if (($urandom % 3) == 0) cyc(($urandom % 2), ($urandom % 2), 1, 1, 1, 1, 1);
            else do_clear();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule